// File: doc/BRIEF.md
# Row Activation Monitor with Aggressor Address Capture

This block sits beside a memory controller and watches the command stream that the controller sends to one DRAM channel. It keeps a record of which row is open in each bank, so it can tell whether a read or write needed an activation. Each such activation advances a 32-bit up-counter. When the counter wraps from all ones to zero, the block raises an interrupt. At the same moment it latches the physical cache-line address of the read or write whose activation caused the wrap.

Host software preloads the counter with any start value through a small register interface. This sets how many activations may pass before the next interrupt, and picking that value at random makes the sampling hard to predict. After the interrupt, software reads the latched address to find a likely aggressor row, then acknowledges the interrupt. Address translation, the DRAM device itself and what software does with the address are handled elsewhere.

Top module: `act_aggressor_monitor`

## Requirements
- R1: A read (op 2) or write (op 3) counts as one activation when its bank has no open row or holds a different row. After it, the accessed row is recorded as open in that bank, and the count reads one higher after the next clock edge.
- R2: A read or write to the row already open in its bank leaves the count unchanged.
- R3: A precharge (op 4) closes the open row of its own bank only. A refresh (op 5) closes the rows of all banks. The next access to a closed bank counts as an activation.
- R4: An explicit activate command (op 1) records its row as open in its bank and does not change the count.
- R5: The counter is CNT_W bits wide (32 by default) and counts upward. An activation while it holds all ones wraps it to zero, and irq is high after that clock edge.
- R6: On a wrap, the capture register (offset 1) takes the line address carried with the read or write that caused the wrap.
- R7: irq and status bit 0 stay set, and the captured address stays unchanged, until software writes the status register (offset 2) with bit 0 set. Further wraps while an interrupt is pending set the sticky status bit 1 and leave the captured address unchanged. A status write with bit 0 clear has no effect. An acknowledge clears both bits.
- R8: A write to offset 0 loads the counter with the written value. If an activation falls in the same cycle, the loaded value wins, and any wrap in that cycle is discarded without raising irq.
- R9: Reads return, with no added latency, the count at offset 0, the captured address at offset 1 and the status word at offset 2 ({overrun, pending} in bits 1:0). All three read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_W | Target row of the command |
| cmd_line_addr | input | ADDR_W | Physical cache-line address carried with a read or write |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register offset |
| csr_wdata | input | CNT_W | Register write data |
| csr_rdata | output | RD_W | Register read data, combinational |
| irq | output | 1 | Interrupt: a wrap is pending acknowledgement |

## Verification
The assertions assume the controller issues at most one command per cycle and never sends a bank number beyond the configured bank count. They also assume register writes are single-cycle strobes with a stable offset. The stimulus issues each command for exactly one cycle followed by an idle cycle, and keeps bank numbers below eight. It drives register writes the same way, except in the one scenario that lines up a counter load with an activation on purpose to exercise the priority rule.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_OPEN    = 3'd1,
    OP_READ    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_CLOSE   = 3'd4,
    OP_REFRESH = 3'd5
  } dram_op_e;

  localparam logic [1:0] REG_COUNT   = 2'd0;
  localparam logic [1:0] REG_CAPTURE = 2'd1;
  localparam logic [1:0] REG_STATUS  = 2'd2;

  function automatic logic is_access(input dram_op_e op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic needs_activation(input logic bank_open, input logic row_match);
    return !(bank_open && row_match);
  endfunction

endpackage

// File: rtl/actmon_row_tracker.sv
module actmon_row_tracker
  import actmon_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int ROW_W = 16,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dram_op_e          op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic              access_hit,
  output logic              access_miss
);

  logic [BANKS-1:0] open_q;
  logic [ROW_W-1:0] row_q [BANKS];
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;
  logic             row_match;

  always_comb begin
    sel_open = 1'b0;
    sel_row  = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank == BANK_W'(b)) begin
        sel_open = open_q[b];
        sel_row  = row_q[b];
      end
    end
  end

  assign row_match   = (sel_row == row);
  assign access_hit  = is_access(op) && !needs_activation(sel_open, row_match);
  assign access_miss = is_access(op) &&  needs_activation(sel_open, row_match);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic this_bank;
      assign this_bank = (bank == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          open_q[b] <= 1'b0;
          row_q[b]  <= '0;
        end else if (op == OP_REFRESH) begin
          open_q[b] <= 1'b0;
        end else if (this_bank) begin
          if (op == OP_CLOSE) begin
            open_q[b] <= 1'b0;
          end else if (op == OP_OPEN || access_miss) begin
            open_q[b] <= 1'b1;
            row_q[b]  <= row;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/actmon_counter.sv
module actmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_evt,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);

  logic [CNT_W-1:0] incr;
  logic             carry;

  assign {carry, incr} = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
  assign ovf_evt = act_evt && !load_evt && carry;

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (load_evt) count <= load_val;
    else if (act_evt)  count <= incr;
  end

endmodule

// File: rtl/actmon_capture.sv
module actmon_capture #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_evt,
  input  logic              ack_evt,
  input  logic [ADDR_W-1:0] line_addr,
  output logic              pending,
  output logic              overrun,
  output logic [ADDR_W-1:0] cap_addr
);

  logic take_new;
  assign take_new = ovf_evt && (!pending || ack_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      overrun  <= 1'b0;
      cap_addr <= '0;
    end else if (take_new) begin
      pending  <= 1'b1;
      overrun  <= 1'b0;
      cap_addr <= line_addr;
    end else if (ack_evt) begin
      pending  <= 1'b0;
      overrun  <= 1'b0;
    end else if (ovf_evt) begin
      overrun  <= 1'b1;
    end
  end

endmodule

// File: rtl/act_aggressor_monitor.sv
module act_aggressor_monitor
  import actmon_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 16,
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 32,
  parameter int RD_W   = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [ADDR_W-1:0] cmd_line_addr,
  input  logic              csr_wr,
  input  logic [1:0]        csr_addr,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [RD_W-1:0]   csr_rdata,
  output logic              irq
);

  dram_op_e         op;
  logic             access_hit;
  logic             act_evt;
  logic             ovf_evt;
  logic             load_evt;
  logic             ack_evt;
  logic [CNT_W-1:0] count;
  logic             pending;
  logic             overrun;
  logic [ADDR_W-1:0] cap_addr;

  assign op       = dram_op_e'(cmd_op);
  assign load_evt = csr_wr && (csr_addr == REG_COUNT);
  assign ack_evt  = csr_wr && (csr_addr == REG_STATUS) && csr_wdata[0];

  actmon_row_tracker #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .op(op), .bank(cmd_bank), .row(cmd_row),
    .access_hit(access_hit), .access_miss(act_evt)
  );

  actmon_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act_evt(act_evt), .load_evt(load_evt),
    .load_val(csr_wdata), .count(count), .ovf_evt(ovf_evt)
  );

  actmon_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ack_evt(ack_evt),
    .line_addr(cmd_line_addr), .pending(pending), .overrun(overrun),
    .cap_addr(cap_addr)
  );

  assign irq = pending;

  always_comb begin
    case (csr_addr)
      REG_COUNT:   csr_rdata = RD_W'(count);
      REG_CAPTURE: csr_rdata = RD_W'(cap_addr);
      REG_STATUS:  csr_rdata = RD_W'({overrun, pending});
      default:     csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/act_aggressor_monitor_chk.sv
module act_aggressor_monitor_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              access_hit,
  input logic              act_evt,
  input logic              ovf_evt,
  input logic              load_evt,
  input logic              ack_evt,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load_val,
  input logic              irq,
  input logic              overrun,
  input logic [ADDR_W-1:0] cap_addr
);

  a_r1_miss_advances: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt && !load_evt |=> count == $past(count) + CNT_W'(1));

  a_r2_hit_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    access_hit && !load_evt |=> $stable(count));

  a_r2_hit_not_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !(access_hit && act_evt));

  a_r5_wrap_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq && count == '0);

  a_r7_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_evt |=> irq && $stable(cap_addr));

  a_r7_overrun_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(irq));

  a_r8_load_suppresses_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !ovf_evt);

  a_r8_load_value_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> count == $past(load_val));

endmodule

bind act_aggressor_monitor act_aggressor_monitor_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .access_hit(access_hit), .act_evt(act_evt),
  .ovf_evt(ovf_evt), .load_evt(load_evt), .ack_evt(ack_evt), .count(count),
  .load_val(csr_wdata), .irq(irq), .overrun(overrun), .cap_addr(cap_addr)
);

// File: tb/act_aggressor_monitor_test.sv
module act_aggressor_monitor_test;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = C_NOP;
  logic [2:0]  cmd_bank = '0;
  logic [15:0] cmd_row = '0;
  logic [39:0] cmd_line_addr = '0;
  logic        csr_wr = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [39:0] csr_rdata;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  act_aggressor_monitor uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_line_addr(cmd_line_addr), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] bank,
                       input logic [15:0] row, input logic [39:0] addr);
    @(negedge clk);
    cmd_op = op; cmd_bank = bank; cmd_row = row; cmd_line_addr = addr;
    @(negedge clk);
    cmd_op = C_NOP;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = 64'(csr_rdata);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    reg_read(2'd0, v); check("R9 count after reset", v, 0);
    reg_read(2'd1, v); check("R9 capture after reset", v, 0);
    reg_read(2'd2, v); check("R9 status after reset", v, 0);
    check("R9 irq after reset", 64'(irq), 0);
  endtask

  task automatic t_miss_hit;
    logic [63:0] v;
    issue(C_RD, 3'd0, 16'd5, 40'h10); reg_read(2'd0, v); check("R1 closed bank read", v, 1);
    issue(C_RD, 3'd0, 16'd5, 40'h11); reg_read(2'd0, v); check("R2 open row read", v, 1);
    issue(C_WR, 3'd0, 16'd6, 40'h12); reg_read(2'd0, v); check("R1 other row write", v, 2);
    issue(C_WR, 3'd1, 16'd5, 40'h13); reg_read(2'd0, v); check("R1 second bank", v, 3);
    issue(C_RD, 3'd1, 16'd5, 40'h14); reg_read(2'd0, v); check("R2 second bank hit", v, 3);
    issue(C_WR, 3'd0, 16'd6, 40'h15); reg_read(2'd0, v); check("R2 write hit", v, 3);
  endtask

  task automatic t_close;
    logic [63:0] v;
    issue(C_PRE, 3'd0, 16'd0, 40'h0);
    issue(C_RD, 3'd0, 16'd6, 40'h20); reg_read(2'd0, v); check("R3 after precharge", v, 4);
    issue(C_RD, 3'd1, 16'd5, 40'h21); reg_read(2'd0, v); check("R3 other bank untouched", v, 4);
    issue(C_REF, 3'd0, 16'd0, 40'h0);
    issue(C_RD, 3'd1, 16'd5, 40'h22); reg_read(2'd0, v); check("R3 refresh closes bank1", v, 5);
    issue(C_RD, 3'd0, 16'd6, 40'h23); reg_read(2'd0, v); check("R3 refresh closes bank0", v, 6);
  endtask

  task automatic t_open;
    logic [63:0] v;
    issue(C_ACT, 3'd2, 16'd9, 40'h0); reg_read(2'd0, v); check("R4 activate not counted", v, 6);
    issue(C_RD, 3'd2, 16'd9, 40'h30); reg_read(2'd0, v); check("R4 row recorded open", v, 6);
    issue(C_RD, 3'd2, 16'd10, 40'h31); reg_read(2'd0, v); check("R4 other row counts", v, 7);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    reg_write(2'd0, 32'hFFFF_FFFE); reg_read(2'd0, v); check("R8 load value", v, 64'hFFFF_FFFE);
    issue(C_RD, 3'd3, 16'd1, 40'h111);
    reg_read(2'd0, v); check("R5 reaches all ones", v, 64'hFFFF_FFFF);
    check("R5 no irq before wrap", 64'(irq), 0);
    issue(C_WR, 3'd3, 16'd2, 40'hAB_CDEF_0222);
    reg_read(2'd0, v); check("R5 wraps to zero", v, 0);
    check("R5 irq after wrap", 64'(irq), 1);
    reg_read(2'd2, v); check("R5 status pending", v, 1);
    reg_read(2'd1, v); check("R6 captured address", v, 64'hAB_CDEF_0222);
  endtask

  task automatic t_overrun;
    logic [63:0] v;
    reg_write(2'd2, 32'h0);
    check("R7 status write without bit0 keeps irq", 64'(irq), 1);
    reg_write(2'd0, 32'hFFFF_FFFF);
    issue(C_RD, 3'd3, 16'd3, 40'h333);
    reg_read(2'd2, v); check("R7 overrun set", v, 3);
    reg_read(2'd1, v); check("R7 capture held", v, 64'hAB_CDEF_0222);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, v); check("R7 ack clears status", v, 0);
    check("R7 ack clears irq", 64'(irq), 0);
    reg_write(2'd0, 32'hFFFF_FFFF);
    issue(C_RD, 3'd3, 16'd4, 40'h444);
    reg_read(2'd1, v); check("R6 new capture after ack", v, 64'h444);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic t_load_race;
    logic [63:0] v;
    reg_write(2'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 2'd0; csr_wdata = 32'd5;
    cmd_op = C_RD; cmd_bank = 3'd4; cmd_row = 16'd1; cmd_line_addr = 40'h555;
    @(negedge clk);
    csr_wr = 1'b0; cmd_op = C_NOP;
    reg_read(2'd0, v); check("R8 load wins over activation", v, 5);
    check("R8 wrap discarded irq", 64'(irq), 0);
    reg_read(2'd1, v); check("R8 capture unchanged", v, 64'h444);
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_close();
    t_open();
    t_wrap();
    t_overrun();
    t_load_race();
    report();
  end

endmodule